// File: doc/BRIEF.md
# RTC Alarm Match Unit

This block decides when a real-time-clock alarm goes off. On every one-second update strobe it compares the freshly updated BCD time (month, date, hour, minute, second) against five alarm bytes. A five-bit repeat code chooses which of those fields must agree. A match sets a sticky alarm flag. The match can also raise an active-low interrupt request, but only when the interrupt enable allows it. In battery-backup mode, a separate backup enable must also be set.

Software services the alarm by reading the flags register, which the surrounding register file signals with a one-cycle read strobe. A read taken while the interrupt is asserted releases the interrupt and leaves the flag set. The next read clears the flag. The interrupt pin is modelled as a level (`irq_n`) plus an output enable (`irq_oe`) that stands in for an open-drain driver. The block has no streaming data path. Every pin is a plain control or status level or a one-cycle strobe, so no valid/ready handshake applies.

The time counters, bus decoding and power-fail detection live outside this block. The register file clears the two enable bits at power-up. While those bits are clear, an alarm only sets the flag.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, `alarm_flag` is 0, `irq_oe` is 0 and `irq_n` is 1.
- R2: Each field is one 8-bit BCD byte, compared as a whole. With repeat code 5'b00000, a match needs all five fields equal: second, minute, hour, date and month.
- R3: `rpt_code` bit 0 is the lowest repeat bit. The codes work as follows:
  - 5'b11111 fires on every strobe.
  - 5'b11110 compares only the second.
  - 5'b11100 compares the second and the minute.
  - 5'b11000 compares the second, minute and hour.
  - 5'b10000 compares every field except the month.
- R4: Any repeat code outside those six fires on every strobe, whatever the field values.
- R5: A match is evaluated only in a cycle with `tick` high. The flag is set at the next clock edge. Cycles without `tick` never set the flag, even if the fields still match.
- R6: A match with `irq_en`=1 and `backup_mode`=0 drives `irq_oe`=1 and `irq_n`=0 from the clock edge that sets the flag. While the interrupt is asserted, the flag is set.
- R7: In backup mode, a match raises the interrupt only if both `irq_en` and `backup_irq_en` are 1. Otherwise it only sets the flag.
- R8: With `irq_en`=0, a match sets the flag and leaves `irq_oe` at 0.
- R9: A `flags_rd` strobe while the interrupt is asserted releases it at the next edge and keeps the flag set. A second strobe then clears the flag.
- R10: A `flags_rd` strobe while no interrupt is asserted clears the flag at the next edge.
- R11: If a match and `flags_rd` happen in the same cycle, the match wins. The flag stays set, and an enabled interrupt stays asserted.
- R12: The interrupt output is gated at all times by the current enables. Dropping `irq_en` releases the pin at once, without clearing the pending request. Restoring `irq_en` asserts the pin again until a flags read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second update strobe; time fields are already updated |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| cur_month | input | 8 | Current month, BCD |
| alm_sec | input | 8 | Alarm seconds, BCD |
| alm_min | input | 8 | Alarm minutes, BCD |
| alm_hour | input | 8 | Alarm hours, BCD |
| alm_date | input | 8 | Alarm day of month, BCD |
| alm_month | input | 8 | Alarm month, BCD |
| rpt_code | input | 5 | Repeat code, bit 0 lowest |
| irq_en | input | 1 | Interrupt enable for alarm |
| backup_irq_en | input | 1 | Permit the interrupt while in backup mode |
| backup_mode | input | 1 | Running from the backup supply |
| flags_rd | input | 1 | One-cycle strobe: flags register was read |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Interrupt level, active low |
| irq_oe | output | 1 | Interrupt driver enable (open-drain stand-in) |

## Verification
The field comparison is tried by making one more field disagree at a time. For each new mismatch, the bench checks two codes: the code that includes the field, which must stay silent, and the next shorter code, which must fire. This separates each code's mask from its neighbour's. Two malformed codes are applied with every field wrong, which tells the fallback apart from a masked full match. The read sequences cover a read with the interrupt asserted, a read with it idle, a read coinciding with a match, and the interrupt under each enable and backup combination. Together they distinguish release from clear and a stored request from a gated output.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned NUM_FIELDS = 5;
  localparam int unsigned RPT_W      = NUM_FIELDS;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4
  } field_e;
endpackage

// File: rtl/alarm_repeat_decode.sv
module alarm_repeat_decode #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] code,
  output logic [N-1:0] part
);
  // A legal code is a run of ones from the top over a run of zeros.
  // A zero bit means the matching field takes part in the compare.
  logic legal;

  always_comb begin
    legal = 1'b1;
    for (int i = 0; i < int'(N) - 1; i++) begin
      if (code[i] && !code[i+1]) legal = 1'b0;
    end
    part = legal ? ~code : '0;
  end
endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 5
) (
  input  logic [N-1:0][W-1:0] now_f,
  input  logic [N-1:0][W-1:0] alm_f,
  input  logic [N-1:0]        part,
  output logic                all_ok
);
  logic [N-1:0] ok;

  for (genvar g = 0; g < int'(N); g++) begin : g_fld
    assign ok[g] = !part[g] || (now_f[g] == alm_f[g]);
  end

  assign all_ok = &ok;
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic flags_rd,
  input  logic irq_en,
  input  logic backup_irq_en,
  input  logic backup_mode,
  output logic alarm_flag,
  output logic irq_n,
  output logic irq_oe
);
  logic gate;
  logic pend;
  logic live;

  assign gate = irq_en && (!backup_mode || backup_irq_en);
  assign live = pend && gate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_flag <= 1'b0;
      pend       <= 1'b0;
    end else begin
      if (hit)                   alarm_flag <= 1'b1;
      else if (flags_rd && !live) alarm_flag <= 1'b0;

      if (hit && gate)   pend <= 1'b1;
      else if (flags_rd) pend <= 1'b0;
    end
  end

  assign irq_oe = live;
  assign irq_n  = !live;

  // R5: a match sets the flag at the next edge
  p_flag_on_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> alarm_flag);

  // R5: the flag only rises after a match
  p_rise_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(hit));

  // R7: the pin is only driven when the enables allow it
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> (irq_en && (!backup_mode || backup_irq_en)));

  // R6: an asserted interrupt implies a set flag
  p_irq_has_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> alarm_flag);

  // R9: a read with no new match releases the pin
  p_read_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_rd && !hit) |=> !irq_oe);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned BCD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [BCD_W-1:0] cur_sec,
  input  logic [BCD_W-1:0] cur_min,
  input  logic [BCD_W-1:0] cur_hour,
  input  logic [BCD_W-1:0] cur_date,
  input  logic [BCD_W-1:0] cur_month,
  input  logic [BCD_W-1:0] alm_sec,
  input  logic [BCD_W-1:0] alm_min,
  input  logic [BCD_W-1:0] alm_hour,
  input  logic [BCD_W-1:0] alm_date,
  input  logic [BCD_W-1:0] alm_month,
  input  logic [4:0]       rpt_code,
  input  logic             irq_en,
  input  logic             backup_irq_en,
  input  logic             backup_mode,
  input  logic             flags_rd,
  output logic             alarm_flag,
  output logic             irq_n,
  output logic             irq_oe
);
  logic [NUM_FIELDS-1:0][BCD_W-1:0] now_f;
  logic [NUM_FIELDS-1:0][BCD_W-1:0] alm_f;
  logic [RPT_W-1:0]                 part;
  logic                             fields_ok;
  logic                             hit;

  always_comb begin
    now_f[FLD_SEC]   = cur_sec;
    now_f[FLD_MIN]   = cur_min;
    now_f[FLD_HOUR]  = cur_hour;
    now_f[FLD_DATE]  = cur_date;
    now_f[FLD_MONTH] = cur_month;
    alm_f[FLD_SEC]   = alm_sec;
    alm_f[FLD_MIN]   = alm_min;
    alm_f[FLD_HOUR]  = alm_hour;
    alm_f[FLD_DATE]  = alm_date;
    alm_f[FLD_MONTH] = alm_month;
  end

  alarm_repeat_decode #(.N(RPT_W)) u_dec (
    .code (rpt_code),
    .part (part)
  );

  alarm_field_cmp #(.W(BCD_W), .N(NUM_FIELDS)) u_cmp (
    .now_f  (now_f),
    .alm_f  (alm_f),
    .part   (part),
    .all_ok (fields_ok)
  );

  assign hit = tick && fields_ok;

  alarm_flag_ctrl u_flag (
    .clk           (clk),
    .rst_n         (rst_n),
    .hit           (hit),
    .flags_rd      (flags_rd),
    .irq_en        (irq_en),
    .backup_irq_en (backup_irq_en),
    .backup_mode   (backup_mode),
    .alarm_flag    (alarm_flag),
    .irq_n         (irq_n),
    .irq_oe        (irq_oe)
  );

  // R3: the every-second code fires on any strobe
  p_every_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rpt_code == 5'b11111) |=> alarm_flag);

  // R2: the full-match code cannot fire on a month mismatch
  p_month_checked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rpt_code == 5'b00000 && cur_month != alm_month && !alarm_flag)
      |=> !alarm_flag);
endmodule

// File: tb/rtc_alarm_match_test.sv
module rtc_alarm_match_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, flags_rd = 1'b0;
  logic irq_en = 1'b0, backup_irq_en = 1'b0, backup_mode = 1'b0;
  logic [4:0] rpt_code = 5'b0;
  logic [7:0] cur [5];
  logic [7:0] alm [5];
  logic alarm_flag, irq_n, irq_oe;

  always #10 clk = ~clk;

  rtc_alarm_match uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cur_sec(cur[0]), .cur_min(cur[1]), .cur_hour(cur[2]),
    .cur_date(cur[3]), .cur_month(cur[4]),
    .alm_sec(alm[0]), .alm_min(alm[1]), .alm_hour(alm[2]),
    .alm_date(alm[3]), .alm_month(alm[4]),
    .rpt_code(rpt_code), .irq_en(irq_en), .backup_irq_en(backup_irq_en),
    .backup_mode(backup_mode), .flags_rd(flags_rd),
    .alarm_flag(alarm_flag), .irq_n(irq_n), .irq_oe(irq_oe)
  );

  typedef struct {
    logic  af;
    logic  irq;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // staged configuration, applied by the driver
  logic [4:0] c_code = 5'b0;
  logic c_en = 1'b0, c_ben = 1'b0, c_bk = 1'b0;
  logic [7:0] t_cur [5];
  logic [7:0] t_alm [5];

  // bench model state
  logic m_af = 1'b0, m_pend = 1'b0;

  function automatic logic [4:0] fields_used(input logic [4:0] code);
    case (code)
      5'b11111: return 5'b00000;
      5'b11110: return 5'b00001;
      5'b11100: return 5'b00011;
      5'b11000: return 5'b00111;
      5'b10000: return 5'b01111;
      5'b00000: return 5'b11111;
      default:  return 5'b00000;
    endcase
  endfunction

  task automatic step(input logic tk, input logic rd, input string tag);
    logic [4:0] used;
    logic match, gate, live;
    exp_t e;
    @(negedge clk);
    tick = tk; flags_rd = rd; rpt_code = c_code;
    irq_en = c_en; backup_irq_en = c_ben; backup_mode = c_bk;
    for (int i = 0; i < 5; i++) begin cur[i] = t_cur[i]; alm[i] = t_alm[i]; end
    used = fields_used(c_code);
    match = tk;
    for (int i = 0; i < 5; i++) if (used[i] && t_cur[i] != t_alm[i]) match = 1'b0;
    gate = c_en && (!c_bk || c_ben);
    live = m_pend && gate;
    if (match) m_af = 1'b1;
    else if (rd && !live) m_af = 1'b0;
    if (match && gate) m_pend = 1'b1;
    else if (rd) m_pend = 1'b0;
    e.af = m_af; e.irq = m_pend && gate; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic clear_all(input string tag);
    step(0, 1, tag);
    step(0, 1, tag);
  endtask

  // monitor: samples 5 ns after the edge that follows each drive
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (alarm_flag !== e.af || irq_oe !== e.irq || irq_n !== !e.irq) begin
          n_bad++;
          $display("FAIL %s: af=%b irq_oe=%b irq_n=%b expected af=%b irq_oe=%b irq_n=%b",
                   e.tag, alarm_flag, irq_oe, irq_n, e.af, e.irq, !e.irq);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    t_cur[0] = 8'h45; t_cur[1] = 8'h30; t_cur[2] = 8'h09;
    t_cur[3] = 8'h15; t_cur[4] = 8'h07;
    for (int i = 0; i < 5; i++) begin
      t_alm[i] = t_cur[i]; cur[i] = t_cur[i]; alm[i] = t_cur[i];
    end
    repeat (3) @(posedge clk);
    #5;
    n_chk++;
    if (alarm_flag !== 1'b0 || irq_oe !== 1'b0 || irq_n !== 1'b1) begin
      n_bad++;
      $display("FAIL R1: af=%b irq_oe=%b irq_n=%b expected 0 0 1", alarm_flag, irq_oe, irq_n);
    end
    @(negedge clk); rst_n = 1'b1;

    c_en = 1'b1; c_code = 5'b00000;
    step(0, 0, "R1 idle after reset");
    step(1, 0, "R2 full match fires");       // R6 interrupt asserted too
    step(0, 0, "R5 no strobe keeps state");
    step(0, 1, "R9 first read releases");
    step(0, 1, "R9 second read clears");

    t_alm[4] = 8'h08;
    step(1, 0, "R2 month mismatch silent");
    c_code = 5'b10000; step(1, 0, "R3 once per month fires"); clear_all("R9 clear");
    t_alm[3] = 8'h16;
    step(1, 0, "R3 date mismatch silent");
    c_code = 5'b11000; step(1, 0, "R3 once per day fires"); clear_all("R9 clear");
    t_alm[2] = 8'h10;
    step(1, 0, "R3 hour mismatch silent");
    c_code = 5'b11100; step(1, 0, "R3 once per hour fires"); clear_all("R9 clear");
    t_alm[1] = 8'h31;
    step(1, 0, "R3 minute mismatch silent");
    c_code = 5'b11110; step(1, 0, "R3 once per minute fires"); clear_all("R9 clear");
    t_alm[0] = 8'h46;
    step(1, 0, "R3 second mismatch silent");
    c_code = 5'b11111; step(1, 0, "R3 every second fires"); clear_all("R9 clear");
    c_code = 5'b10101; step(1, 0, "R4 malformed code fires"); clear_all("R9 clear");
    c_code = 5'b01111; step(1, 0, "R4 malformed code fires"); clear_all("R9 clear");
    c_code = 5'b00000; step(1, 0, "R2 all fields wrong silent");

    for (int i = 0; i < 5; i++) t_alm[i] = t_cur[i];
    step(1, 0, "R5 strobe match"); clear_all("R9 clear");
    step(0, 0, "R5 no retrigger without strobe");
    step(0, 0, "R5 no retrigger without strobe");

    c_en = 1'b0;
    step(1, 0, "R8 flag only");
    step(0, 1, "R10 single read clears");

    c_en = 1'b1; c_bk = 1'b1; c_ben = 1'b0;
    step(1, 0, "R7 backup without permit");
    step(0, 1, "R10 read clears");
    c_ben = 1'b1;
    step(1, 0, "R7 backup with both enables");
    step(1, 1, "R11 match beats read");
    c_bk = 1'b0; c_en = 1'b0;
    step(0, 0, "R12 enable dropped releases pin");
    c_en = 1'b1;
    step(0, 0, "R12 enable restored reasserts");
    clear_all("R9 clear");
    step(0, 0, "R10 idle after clear");

    repeat (3) @(posedge clk);
    #5;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule